// File: doc/BRIEF.md
# Configuration Access Router with Byte Lanes

The block takes one configuration request at a time and decides where it goes. A request names a bus, a device, a function, a register offset, an access size of 1, 2 or 4 bytes and, for writes, the data. The block then either answers at once with a "not found" or "bad register" status, or issues one access to one of three targets: the controller's own configuration space, a window that produces type-0 configuration cycles, or a window that produces type-1 configuration cycles.

Every target access is one aligned 32-bit word. For reads the block picks the requested bytes out of the returned word. For writes it moves the data onto the proper byte lanes and produces byte strobes. The block drops requests to devices that cannot exist: only device 0 is reachable on the root bus and on the bus directly below it. It also drops requests that would have to cross a link that is down. A dropped read returns all-ones. A single-cycle done pulse with a status code closes every request.

Top module: `cfg_access_router`

## Requirements
- R1: After reset `rsp_done`, `tgt_valid` and `busy` are all low.
- R2: A request on `root_bus` goes to target code 0 (own space). Any other bus goes to code 1 (type-0 window) when `req_up_bus` equals `root_bus`, and to code 2 (type-1 window) otherwise.
- R3: A nonzero device number is rejected with status 1 (not found) when `req_bus` equals `root_bus` or `req_up_bus` equals `root_bus`. No target access is made, and a rejected read returns 32'hFFFFFFFF. Deeper buses accept any device number.
- R4: When `link_up` is low, any request whose bus is not `root_bus` is rejected with status 1 and makes no access. Requests on the root bus still proceed.
- R5: A size other than 1, 2 or 4 gives status 2 (bad register), makes no access and returns read data 0. A request that is also not found reports status 1.
- R6: A read returns the target word shifted right by 8·(offset mod 4) and masked to 8 bits for size 1 or to 16 bits for size 2. Size 4 returns the whole word.
- R7: A write of size 4 uses strobes 4'b1111 with the data unshifted. Size 2 places the low 16 data bits at byte offset&2 with strobes 4'b0011 shifted by that amount. Size 1 places the low byte at offset&3 with strobe 4'b0001 shifted by that amount.
- R8: `tgt_addr` is offset&~3 for code 0, and (function<<16)|(offset&0xFFFC) for codes 1 and 2. `tgt_busdev` is (bus<<24)|(device<<19) for codes 1 and 2, and 0 for code 0.
- R9: A rejected request gives `rsp_done` in the cycle after the edge that accepts it. An accepted request raises `tgt_valid` in that same cycle and holds it and all target fields stable until `tgt_ready`. `rsp_done` follows in the cycle after the handshake edge. Requests offered while `busy` is high are ignored.
- R10: A completed access reports status 0. Write responses carry data 0. Status code 3 is never produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| root_bus | input | 8 | Bus number of the root |
| link_up | input | 1 | Downstream link is up |
| req_valid | input | 1 | Request offered (taken when not busy) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bus | input | 8 | Target bus number |
| req_up_bus | input | 8 | Bus upstream of the target bus |
| req_dev | input | 5 | Device number |
| req_fn | input | 3 | Function number |
| req_off | input | 12 | Register byte offset |
| req_size | input | 3 | Access size in bytes |
| req_wdata | input | 32 | Write data, right-aligned |
| busy | output | 1 | A target access is in flight |
| tgt_valid | output | 1 | Target access request |
| tgt_ready | input | 1 | Target accepts or completes the access |
| tgt_write | output | 1 | Target access is a write |
| tgt_sel | output | 2 | 0 own space, 1 type-0 window, 2 type-1 window |
| tgt_addr | output | 32 | Aligned word address within the target |
| tgt_busdev | output | 32 | Bus/device target field for the windows |
| tgt_be | output | 4 | Write byte strobes |
| tgt_wdata | output | 32 | Lane-shifted write data |
| tgt_rdata | input | 32 | Word returned by the target at the handshake |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_status | output | 2 | 0 ok, 1 not found, 2 bad register |
| rsp_rdata | output | 32 | Read result |

## Verification
A rejected request has one register between the accepting edge and `rsp_done`, so it is due one cycle later. An accepted request is due two cycles later, plus one cycle for each cycle the target holds `tgt_ready` low. The bench counts falling edges from the accepting edge up to the done pulse and compares that count against these figures. It samples the target fields on the falling edge where it raises `tgt_ready`, so it sees exactly what the handshake edge consumes. In one stalled access the bench offers a competing request while the block is busy. It then confirms that the captured fields are unchanged and that no extra done pulse follows.

// File: rtl/cfg_access_router.sv
module cfg_access_router #(
  parameter int BUS_W = 8,
  parameter int DEV_W = 5,
  parameter int FN_W  = 3,
  parameter int OFF_W = 12,
  parameter int DW    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BUS_W-1:0] root_bus,
  input  logic             link_up,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [BUS_W-1:0] req_bus,
  input  logic [BUS_W-1:0] req_up_bus,
  input  logic [DEV_W-1:0] req_dev,
  input  logic [FN_W-1:0]  req_fn,
  input  logic [OFF_W-1:0] req_off,
  input  logic [2:0]       req_size,
  input  logic [DW-1:0]    req_wdata,
  output logic             busy,
  output logic             tgt_valid,
  input  logic             tgt_ready,
  output logic             tgt_write,
  output logic [1:0]       tgt_sel,
  output logic [DW-1:0]    tgt_addr,
  output logic [DW-1:0]    tgt_busdev,
  output logic [DW/8-1:0]  tgt_be,
  output logic [DW-1:0]    tgt_wdata,
  input  logic [DW-1:0]    tgt_rdata,
  output logic             rsp_done,
  output logic [1:0]       rsp_status,
  output logic [DW-1:0]    rsp_rdata
);
  localparam int BE_W = DW / 8;
  localparam logic [1:0] ST_OK = 2'd0, ST_NF = 2'd1, ST_BAD = 2'd2;
  localparam logic [1:0] SEL_OWN = 2'd0, SEL_T0 = 2'd1, SEL_T1 = 2'd2;

  wire on_root    = (req_bus == root_bus);
  wire below_root = (req_up_bus == root_bus);
  wire not_found  = ((req_dev != '0) && (on_root || below_root)) || (!on_root && !link_up);
  wire size_ok    = (req_size == 3'd1) || (req_size == 3'd2) || (req_size == 3'd4);

  wire [1:0] sel_d = on_root ? SEL_OWN : (below_root ? SEL_T0 : SEL_T1);
  wire [1:0] wr_lane = (req_size == 3'd4) ? 2'd0 :
                       (req_size == 3'd2) ? {req_off[1], 1'b0} : req_off[1:0];
  wire [1:0] rd_lane = (req_size == 3'd4) ? 2'd0 : req_off[1:0];

  wire [DW-1:0] word_off = DW'({req_off[OFF_W-1:2], 2'b00});
  wire [DW-1:0] addr_d   = on_root ? word_off : ((DW'(req_fn) << 16) | word_off);
  wire [DW-1:0] busdev_d = on_root ? '0 : ((DW'(req_bus) << 24) | (DW'(req_dev) << 19));

  logic [BE_W-1:0] be_d;
  logic [DW-1:0]   wmask_d;
  always_comb begin
    case (req_size)
      3'd1:    begin be_d = BE_W'(1) << wr_lane; wmask_d = DW'(req_wdata[7:0]);  end
      3'd2:    begin be_d = BE_W'(3) << wr_lane; wmask_d = DW'(req_wdata[15:0]); end
      default: begin be_d = '1;                  wmask_d = req_wdata;             end
    endcase
  end

  logic          busy_q, last_wr;
  logic [2:0]    size_q;
  logic [1:0]    lane_q;

  wire [DW-1:0] rd_shift = tgt_rdata >> {lane_q, 3'b000};
  wire [DW-1:0] rd_word  = (size_q == 3'd1) ? DW'(rd_shift[7:0]) :
                           (size_q == 3'd2) ? DW'(rd_shift[15:0]) : rd_shift;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0; last_wr <= 1'b0; size_q <= '0; lane_q <= '0;
      tgt_write <= 1'b0; tgt_sel <= '0; tgt_addr <= '0; tgt_busdev <= '0;
      tgt_be <= '0; tgt_wdata <= '0;
      rsp_done <= 1'b0; rsp_status <= ST_OK; rsp_rdata <= '0;
    end else begin
      rsp_done <= 1'b0;
      if (!busy_q) begin
        if (req_valid) begin
          last_wr <= req_write;
          if (not_found) begin
            rsp_done <= 1'b1; rsp_status <= ST_NF;
            rsp_rdata <= req_write ? '0 : '1;
          end else if (!size_ok) begin
            rsp_done <= 1'b1; rsp_status <= ST_BAD; rsp_rdata <= '0;
          end else begin
            busy_q     <= 1'b1;
            tgt_write  <= req_write;
            tgt_sel    <= sel_d;
            tgt_addr   <= addr_d;
            tgt_busdev <= busdev_d;
            tgt_be     <= req_write ? be_d : '0;
            tgt_wdata  <= req_write ? (wmask_d << {wr_lane, 3'b000}) : '0;
            size_q     <= req_size;
            lane_q     <= rd_lane;
          end
        end
      end else if (tgt_ready) begin
        busy_q     <= 1'b0;
        rsp_done   <= 1'b1;
        rsp_status <= ST_OK;
        rsp_rdata  <= tgt_write ? '0 : rd_word;
      end
    end
  end

  assign busy      = busy_q;
  assign tgt_valid = busy_q;

  a_r9_hold_fields: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_valid && !tgt_ready |=> tgt_valid && $stable(tgt_addr) && $stable(tgt_be)
                               && $stable(tgt_wdata) && $stable(tgt_sel));
  a_r9_no_done_in_flight: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_valid |-> !rsp_done);
  a_r3_reject_ones: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done && rsp_status == ST_NF && !last_wr |-> rsp_rdata == '1);
  a_r7_strobe_count: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_valid && tgt_write |-> ($countones(tgt_be) == 1 || $countones(tgt_be) == 2
                                || $countones(tgt_be) == 4));
  a_r10_status_code: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> rsp_status != 2'd3);
  a_r4_link_gate: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tgt_valid) && tgt_sel != SEL_OWN |-> $past(link_up));
endmodule

// File: tb/sim_cfg_access_router.sv
module sim_cfg_access_router;
  logic clk = 0, rst_n = 0;
  always #10 clk = ~clk;

  logic [7:0] root_bus = 8'h10;
  logic link_up = 1, req_valid = 0, req_write = 0;
  logic [7:0] req_bus = 0, req_up_bus = 0;
  logic [4:0] req_dev = 0;
  logic [2:0] req_fn = 0, req_size = 0;
  logic [11:0] req_off = 0;
  logic [31:0] req_wdata = 0;
  logic busy, tgt_valid, tgt_write, rsp_done;
  logic tgt_ready = 0;
  logic [1:0] tgt_sel, rsp_status;
  logic [31:0] tgt_addr, tgt_busdev, tgt_wdata, tgt_rdata, rsp_rdata;
  logic [3:0] tgt_be;

  function automatic logic [31:0] mdl(input logic [1:0] s, input logic [31:0] a);
    return (a * 32'h9E3779B1) ^ {s, 30'h0} ^ 32'h5A5A1234;
  endfunction
  assign tgt_rdata = mdl(tgt_sel, tgt_addr);

  cfg_access_router u0 (.*);

  int n_chk = 0, n_bad = 0, cyc = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL R9 watchdog expired got %0d expected <150000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  int lat, stall_cnt, extra;
  logic seen;
  logic [1:0] c_sel, g_status;
  logic [31:0] c_addr, c_busdev, c_wdata, g_rdata;
  logic [3:0] c_be;
  logic c_wr;

  task automatic run(input logic wr, input logic [7:0] bus, input logic [7:0] up,
                     input logic [4:0] dev, input logic [2:0] fn, input logic [11:0] off,
                     input logic [2:0] sz, input logic [31:0] wd, input int stall,
                     input logic intrude);
    @(negedge clk);
    req_write = wr; req_bus = bus; req_up_bus = up; req_dev = dev; req_fn = fn;
    req_off = off; req_size = sz; req_wdata = wd; req_valid = 1;
    stall_cnt = stall; seen = 0; tgt_ready = 0;
    @(negedge clk);
    req_valid = 0; lat = 1;
    while (!rsp_done && lat < 50) begin
      if (tgt_valid) begin
        seen = 1;
        if (stall_cnt > 0) begin
          tgt_ready = 0; stall_cnt--;
          if (intrude) begin
            req_valid = 1; req_bus = root_bus; req_dev = 5'd7; req_write = ~wr;
            req_off = 12'h0; req_size = 3'd4;
          end
        end else begin
          tgt_ready = 1; req_valid = 0;
          c_sel = tgt_sel; c_addr = tgt_addr; c_busdev = tgt_busdev;
          c_be = tgt_be; c_wdata = tgt_wdata; c_wr = tgt_write;
        end
      end
      @(negedge clk);
      lat++;
    end
    tgt_ready = 0; req_valid = 0;
    g_status = rsp_status; g_rdata = rsp_rdata;
    extra = 0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      if (rsp_done) extra++;
    end
  endtask

  task automatic full(input logic wr, input logic [7:0] bus, input logic [7:0] up,
                      input logic [4:0] dev, input logic [2:0] fn, input logic [11:0] off,
                      input logic [2:0] sz, input logic [31:0] wd, input int stall,
                      input logic intrude);
    logic on_root, below, nf, bad;
    logic [1:0] esel, wl;
    logic [31:0] eaddr, ebd, w, er, emask;
    logic [3:0] ebe;
    on_root = (bus == root_bus); below = (up == root_bus);
    nf = ((dev != 0) && (on_root || below)) || (!on_root && !link_up);
    bad = !(sz == 1 || sz == 2 || sz == 4);
    esel = on_root ? 2'd0 : (below ? 2'd1 : 2'd2);
    eaddr = {20'h0, off[11:2], 2'b00};
    if (!on_root) eaddr = eaddr | ({29'h0, fn} << 16);
    ebd = on_root ? 32'h0 : (({24'h0, bus} << 24) | ({27'h0, dev} << 19));
    run(wr, bus, up, dev, fn, off, sz, wd, stall, intrude);
    if (nf) begin
      chk("R3/R4 status not found", {30'h0, g_status}, 32'd1);
      chk("R3/R4 rejected data", g_rdata, wr ? 32'h0 : 32'hFFFFFFFF);
      chk("R3/R4 no access", {31'h0, seen}, 32'd0);
      chk("R9 reject latency", lat, 32'd1);
    end else if (bad) begin
      chk("R5 status bad register", {30'h0, g_status}, 32'd2);
      chk("R5 bad data", g_rdata, 32'h0);
      chk("R5 no access", {31'h0, seen}, 32'd0);
      chk("R9 bad latency", lat, 32'd1);
    end else begin
      chk("R10 status ok", {30'h0, g_status}, 32'd0);
      chk("R9 access latency", lat, stall + 2);
      chk("R2 target code", {30'h0, c_sel}, {30'h0, esel});
      chk("R8 word address", c_addr, eaddr);
      chk("R8 bus/device field", c_busdev, ebd);
      chk("R9 write flag", {31'h0, c_wr}, {31'h0, wr});
      chk("R9 no extra done", extra, 32'd0);
      if (wr) begin
        wl = (sz == 4) ? 2'd0 : (sz == 2) ? {off[1], 1'b0} : off[1:0];
        ebe = (sz == 4) ? 4'hF : (sz == 2) ? (4'b0011 << wl) : (4'b0001 << wl);
        emask = (sz == 4) ? wd : (sz == 2) ? {16'h0, wd[15:0]} : {24'h0, wd[7:0]};
        chk("R7 strobes", {28'h0, c_be}, {28'h0, ebe});
        chk("R7 lane data", c_wdata, emask << (8 * wl));
        chk("R10 write response data", g_rdata, 32'h0);
      end else begin
        w = mdl(esel, eaddr);
        er = (sz == 4) ? w : (w >> (8 * off[1:0]));
        if (sz == 1) er = er & 32'hFF;
        if (sz == 2) er = er & 32'hFFFF;
        chk("R6 read lanes", g_rdata, er);
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset done", {31'h0, rsp_done}, 0);
    chk("R1 reset valid", {31'h0, tgt_valid}, 0);
    chk("R1 reset busy", {31'h0, busy}, 0);
    rst_n = 1;
    // R2 R6 R7 R8 sweep over targets, sizes, offsets
    for (int t = 0; t < 3; t++)
      for (int s = 0; s < 3; s++)
        for (int o = 0; o < 8; o++)
          for (int w = 0; w < 2; w++) begin
            logic [7:0] b, u;
            logic [2:0] sz;
            b = (t == 0) ? 8'h10 : (t == 1) ? 8'h11 : 8'h22;
            u = (t == 0) ? 8'h0F : (t == 1) ? 8'h10 : 8'h11;
            sz = (s == 0) ? 3'd1 : (s == 1) ? 3'd2 : 3'd4;
            full(w[0], b, u, (t == 2) ? 5'(o + 3) : 5'd0, 3'(o + t), 12'(12'h3F8 + o + 16 * t),
                 sz, 32'hC3A5_9600 + o, 0, 0);
          end
    // R3 device filter sweep
    for (int d = 0; d < 32; d++) begin
      full(0, 8'h10, 8'h00, 5'(d), 3'd1, 12'h008, 3'd4, 0, 0, 0);
      full(1, 8'h11, 8'h10, 5'(d), 3'd2, 12'h00C, 3'd4, 32'h1234, 0, 0);
      full(0, 8'h23, 8'h11, 5'(d), 3'd3, 12'h010, 3'd2, 0, 0, 0);
    end
    // R4 link down
    link_up = 0;
    full(0, 8'h10, 8'h00, 0, 0, 12'h004, 3'd4, 0, 0, 0);
    full(0, 8'h11, 8'h10, 0, 0, 12'h004, 3'd4, 0, 0, 0);
    full(1, 8'h30, 8'h11, 0, 0, 12'h004, 3'd1, 32'hFF, 0, 0);
    link_up = 1;
    // R5 bad sizes, with and without not-found priority
    for (int s = 0; s < 8; s++) begin
      full(0, 8'h11, 8'h10, 0, 0, 12'h020, 3'(s), 0, 0, 0);
      full(1, 8'h10, 8'h00, 5'd2, 0, 12'h020, 3'(s), 32'h55, 0, 0);
    end
    // R9 stalls and ignored request while busy
    for (int st = 1; st < 5; st++) begin
      full(0, 8'h22, 8'h11, 5'd9, 3'd5, 12'h1F3, 3'd2, 0, st, 1);
      full(1, 8'h11, 8'h10, 5'd0, 3'd6, 12'h0A6, 3'd1, 32'h77, st, 1);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule